// File: doc/BRIEF.md
# Saturating Float-to-Integer Converter

This block turns a 32-bit single-precision floating-point word into a 32-bit two's-complement integer. The fraction is always dropped, so results round toward zero. An input that is too large for the integer range does not raise an exception. The output is clamped to the largest positive or most negative integer, and only the sign of the input picks which one.

The datapath has three steps. It restores the hidden bit and moves the 24-bit significand into place with a shifter whose shift amount comes from the unbiased exponent. It negates the magnitude when the input is negative. One register stage then holds the result together with a valid strobe.

The range check looks only at the exponent field, compared against a fixed limit. Because of this, infinities and NaNs fall into the saturation branch like any other oversized value.

Top module: `f2i_sat`

## Requirements
- R1: For an input whose biased exponent (bits 30..23) is at most 157, the output is the input value truncated toward zero.
- R2: For an input with sign bit 31 clear and a biased exponent above 157, the output is 0x7FFFFFFF.
- R3: For an input with sign bit 31 set and a biased exponent above 157, the output is 0x80000000.
- R4: Infinities and NaNs (biased exponent 255) saturate by sign, with the same values as R2 and R3, whatever the fraction bits hold.
- R5: An input with a biased exponent below 127 gives 0. This includes both zeros, denormals, and every magnitude below one.
- R6: For a biased exponent e from 127 to 157, the magnitude is the 24-bit significand with its hidden bit. It is shifted left by e-150 when e is 150 or more, and right by 150-e otherwise, and the bits shifted out are lost.
- R7: A negative in-range input gives the two's-complement negation of its magnitude, so a negative value above -1 gives 0.
- R8: `out_valid` is high in the cycle after a cycle with `in_valid` high, and `out_data` then carries that input's result.
- R9: Reset (active-low `rst_n`) clears `out_data` and `out_valid` to 0.
- R10: While `in_valid` is low, `out_data` keeps its value and `out_valid` goes low one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks `in_data` as a value to convert |
| in_data | input | 32 | Single-precision input word |
| out_valid | output | 1 | Registered result is new this cycle |
| out_data | output | 32 | Registered two's-complement result |

## Verification
The bench builds the block with its default exponent limit of 157. With that limit, the vectors reach the edge of the range exactly: the largest in-range magnitudes of either sign and the first exponent that saturates. Its vectors also cover each side of the align point at exponent 150, the cut at exponent 127, negative values that truncate to zero, and NaNs with either sign. Directed steps after the vectors check the one-cycle latency, the output holding while no input is offered, and a reset in the middle of a run.

// File: rtl/f2i_sat.sv
module f2i_sat #(
  parameter int EXP_LIMIT = 157
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  output logic        out_valid,
  output logic [31:0] out_data
);

  localparam int FRAC_W = 23;
  localparam int BIAS   = 127;
  localparam int ALIGN  = BIAS + FRAC_W;

  localparam logic [7:0]  LIM_E   = 8'(EXP_LIMIT);
  localparam logic [7:0]  BIAS_E  = 8'(BIAS);
  localparam logic [7:0]  ALIGN_E = 8'(ALIGN);
  localparam logic [31:0] POS_MAX = 32'h7FFF_FFFF;
  localparam logic [31:0] NEG_MAX = 32'h8000_0000;

  logic        sgn;
  logic [7:0]  expo;
  logic [31:0] signif;
  logic        too_big;
  logic        below_one;
  logic [31:0] mag;
  logic [31:0] result;

  assign sgn       = in_data[31];
  assign expo      = in_data[30:23];
  assign signif    = {8'd0, 1'b1, in_data[FRAC_W-1:0]};
  assign too_big   = expo > LIM_E;
  assign below_one = expo < BIAS_E;

  assign mag = (expo >= ALIGN_E) ? (signif << (expo - ALIGN_E))
                                 : (signif >> (ALIGN_E - expo));

  always_comb begin
    if (too_big)        result = sgn ? NEG_MAX : POS_MAX;
    else if (below_one) result = '0;
    else if (sgn)       result = -mag;
    else                result = mag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= result;
    end
  end

  p_sat_pos_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_data[31] && in_data[30:23] > LIM_E) |=> (out_data == POS_MAX));

  p_sat_neg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data[31] && in_data[30:23] > LIM_E) |=> (out_data == NEG_MAX));

  p_special_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data[30:23] == 8'hFF) |=> (out_data[31] == $past(in_data[31])));

  p_small_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data[30:23] < BIAS_E) |=> (out_data == 32'd0));

  p_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data[30:23] >= BIAS_E && in_data[30:23] <= LIM_E)
      |=> (out_data[31] == $past(in_data[31])));

  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_data)));

endmodule

// File: tb/sim_f2i_sat.sv
module sim_f2i_sat;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic [31:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  f2i_sat u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  localparam int NV = 28;
  // {requirement number, input, expected}
  localparam logic [71:0] VEC [NV] = '{
    {8'd1, 32'h3F80_0000, 32'h0000_0001},  // R1  1.0
    {8'd1, 32'h3FC0_0000, 32'h0000_0001},  // R1  1.5
    {8'd1, 32'h42C9_0000, 32'h0000_0064},  // R1  100.5
    {8'd7, 32'hBF80_0000, 32'hFFFF_FFFF},  // R7  -1.0
    {8'd7, 32'hC030_0000, 32'hFFFF_FFFE},  // R7  -2.75
    {8'd7, 32'hC2C9_0000, 32'hFFFF_FF9C},  // R7  -100.5
    {8'd7, 32'hBF40_0000, 32'h0000_0000},  // R7  -0.75
    {8'd5, 32'h3F00_0000, 32'h0000_0000},  // R5  0.5
    {8'd5, 32'h3F7F_FFFF, 32'h0000_0000},  // R5  just below 1
    {8'd5, 32'h0000_0000, 32'h0000_0000},  // R5  +0
    {8'd5, 32'h8000_0000, 32'h0000_0000},  // R5  -0
    {8'd5, 32'h0000_0001, 32'h0000_0000},  // R5  denormal
    {8'd6, 32'h4A80_0000, 32'h0040_0000},  // R6  e=149 right by 1
    {8'd6, 32'h4B00_0000, 32'h0080_0000},  // R6  e=150 no shift
    {8'd6, 32'h4B7F_FFFF, 32'h00FF_FFFF},  // R6  e=150 full significand
    {8'd6, 32'h4B80_0000, 32'h0100_0000},  // R6  e=151 left by 1
    {8'd1, 32'h4E80_0000, 32'h4000_0000},  // R1  2^30
    {8'd1, 32'h4EFF_FFFF, 32'h7FFF_FF80},  // R1  largest in range
    {8'd7, 32'hCE80_0000, 32'hC000_0000},  // R7  -2^30
    {8'd7, 32'hCEFF_FFFF, 32'h8000_0080},  // R7  most negative in range
    {8'd2, 32'h4F00_0000, 32'h7FFF_FFFF},  // R2  2^31
    {8'd2, 32'h5F00_0000, 32'h7FFF_FFFF},  // R2  large
    {8'd3, 32'hCF00_0000, 32'h8000_0000},  // R3  -2^31
    {8'd3, 32'hE000_0000, 32'h8000_0000},  // R3  large negative
    {8'd4, 32'h7F80_0000, 32'h7FFF_FFFF},  // R4  +inf
    {8'd4, 32'hFF80_0000, 32'h8000_0000},  // R4  -inf
    {8'd4, 32'h7FC0_0000, 32'h7FFF_FFFF},  // R4  NaN
    {8'd4, 32'hFFC0_0001, 32'h8000_0000}   // R4  negative NaN
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [31:0] d);
    @(negedge clk);
    in_valid = v;
    in_data  = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(9, {31'd0, out_valid}, 32'd0);  // R9 reset state
    check(9, out_data, 32'd0);            // R9
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i][63:32]);
      check(int'(VEC[i][71:64]), out_data, VEC[i][31:0]);
      check(8, {31'd0, out_valid}, 32'd1);  // R8
    end

    // R10: idle input with changed data must not disturb the output
    drive(1'b1, 32'h4120_0000);             // 10.0
    check(8, out_data, 32'h0000_000A);      // R8
    drive(1'b0, 32'hC120_0000);
    check(10, {31'd0, out_valid}, 32'd0);   // R10
    check(10, out_data, 32'h0000_000A);     // R10
    drive(1'b0, 32'h7F80_0000);
    check(10, out_data, 32'h0000_000A);     // R10

    // R8: result appears in the cycle right after the strobe
    drive(1'b1, 32'hC120_0000);
    check(8, {31'd0, out_valid}, 32'd1);    // R8
    check(8, out_data, 32'hFFFF_FFF6);      // R8

    // R9: reset mid-run clears both outputs
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(9, {31'd0, out_valid}, 32'd0);    // R9
    check(9, out_data, 32'd0);              // R9
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b1, 32'h4000_0000);             // 2.0
    check(1, out_data, 32'h0000_0002);      // R1

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule